// File: doc/BRIEF.md
# External Interrupt Sense and Flag Unit

This block watches one external interrupt pin and turns its activity into an interrupt request. A two-bit sense selection chooses what counts as an event: a falling edge, a rising edge, any change of level, or a low level held on the pin. The pin is sampled whether or not something else drives it. Software that drives the pin as an output can therefore raise the interrupt on purpose. In the three edge modes a detected event sets a sticky flag. In low-level mode no flag is kept, and the request follows the pin for as long as it stays low.

A second sticky flag records overflow pulses from a timer. Both flags are visible in one small flag register. Software clears a flag by writing a one to its bit, and the CPU's vector acknowledge clears it by hardware. Each source raises its request only when the global interrupt enable, its own enable and its flag are all set. Choosing between several pending sources is left to the interrupt controller that uses these requests.

The sense code 00 selects low-level mode. A control register that resets to zero therefore starts the unit in level mode.

Top module: `xint_sense_flag`

## Requirements
- R1: After reset every bit of `flag_rd` reads 0 and both `irq_ext` and `irq_tmr` are low.
- R2: With `sense_mode` = 2'b10 (falling edge), a high-to-low change of the pin sets `flag_rd[6]`. A low-to-high change does not set it.
- R3: With `sense_mode` = 2'b11 (rising edge), a low-to-high change sets `flag_rd[6]`. A high-to-low change does not set it.
- R4: With `sense_mode` = 2'b01 (any change), both directions of change set `flag_rd[6]`.
- R5: With `sense_mode` = 2'b00 (low level), `irq_ext` is high while `gie` and `ext_en` are high and the synchronized pin is low. In this mode `flag_rd[6]` always reads 0, and a flag held when entering the mode is discarded.
- R6: A write with `wr_data[6]` = 1 clears the external flag, and a write with `wr_data[4]` = 1 clears the timer flag. A write with 0 in a flag bit leaves that flag unchanged.
- R7: A one-cycle `ack_ext` pulse clears the external flag, and a one-cycle `ack_tmr` pulse clears the timer flag.
- R8: When a set event and a clear (a write of 1 or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: A one-cycle `tmr_ovf` pulse sets `flag_rd[4]`. `irq_tmr` is high exactly when `gie`, `tmr_en` and the timer flag are all set.
- R10: In the edge modes an event sets the flag even while the enables are low. `irq_ext` is high only when `gie`, `ext_en` and the external flag are all high.
- R11: `flag_rd` bits other than 6 and 4 always read 0, and writing ones to them has no effect.
- R12: The pin passes through a two-flop synchronizer. An edge sets the flag on the third rising clock edge after the pin changes. A level request appears after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_raw | input | 1 | Asynchronous external pin level |
| sense_mode | input | 2 | 00 low level, 01 any change, 10 falling, 11 rising |
| ext_en | input | 1 | External source enable |
| tmr_en | input | 1 | Timer overflow source enable |
| gie | input | 1 | Global interrupt enable |
| tmr_ovf | input | 1 | Timer overflow pulse |
| wr_en | input | 1 | Flag register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the flag at that position |
| ack_ext | input | 1 | Vector acknowledge for the external source |
| ack_tmr | input | 1 | Vector acknowledge for the timer source |
| flag_rd | output | 8 | Flag register read value |
| irq_ext | output | 1 | External interrupt request |
| irq_tmr | output | 1 | Timer interrupt request |

## Verification
The hardest case to reach from the ports is an edge event that lands in the same clock as a write-one clear. The event exists inside the block for a single cycle, two synchronizer stages after the pin moves. The bench changes the pin, counts two clock edges and raises the write strobe for exactly the edge on which the event is due. The same is done with an overflow pulse against an acknowledge. A second hard case is a flag held when entering low-level mode. The bench sets the flag in falling mode, switches to level mode, then returns to an edge mode to show the flag was discarded.

// File: rtl/xint_pkg.sv
// Shared types for the external interrupt sense unit.
// Assumes the sense code is driven from a control register field.
package xint_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    // Sense selection; 00 is level so a cleared control register picks it.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;
endpackage

// File: rtl/xint_sync.sv
// Multi-stage synchronizer for an asynchronous pin.
// Assumes the pin is quasi-static relative to the clock; output lags by STAGES edges.
module xint_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    timeunit 1ns;
    timeprecision 100ps;

    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the pin one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= d;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xint_sense.sv
// Turns the synchronized pin into a one-cycle edge event or a level request.
// Assumes pin_s is already in the clock domain; idle level is high.
module xint_sense
    import xint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_s,
    input  sense_mode_e mode,
    output logic        edge_evt,
    output logic        level_act
);
    timeunit 1ns;
    timeprecision 100ps;

    logic prev;
    logic rise;
    logic fall;

    // Remember last cycle's sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= pin_s;
    end

    assign rise = pin_s & ~prev;
    assign fall = ~pin_s & prev;

    // Choose the event kind selected by the sense mode.
    always_comb begin
        edge_evt  = 1'b0;
        level_act = 1'b0;
        unique case (mode)
            SENSE_LOW:  level_act = ~pin_s;
            SENSE_ANY:  edge_evt  = rise | fall;
            SENSE_FALL: edge_evt  = fall;
            SENSE_RISE: edge_evt  = rise;
            default:    edge_evt  = 1'b0;
        endcase
    end
endmodule

// File: rtl/xint_flag_bit.sv
// One sticky interrupt flag.
// Priority: forced clear, then set, then write-one or acknowledge clear.
module xint_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wclr_i,
    input  logic ack_i,
    input  logic force_clr_i,
    output logic q
);
    timeunit 1ns;
    timeprecision 100ps;

    // Update the flag; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                q <= 1'b0;
        else if (force_clr_i)      q <= 1'b0;
        else if (set_i)            q <= 1'b1;
        else if (wclr_i || ack_i)  q <= 1'b0;
    end
endmodule

// File: rtl/xint_sense_flag.sv
// External interrupt sense unit with its flag register.
// Holds the pin event flag and a timer overflow flag; raises gated requests.
// Assumes wr_en and ack pulses last one cycle and tmr_ovf is a one-cycle pulse.
module xint_sense_flag
    import xint_pkg::*;
#(
    parameter int REG_W       = 8,
    parameter int EXT_BIT     = 6,
    parameter int TMR_BIT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic [1:0]       sense_mode,
    input  logic             ext_en,
    input  logic             tmr_en,
    input  logic             gie,
    input  logic             tmr_ovf,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             ack_ext,
    input  logic             ack_tmr,
    output logic [REG_W-1:0] flag_rd,
    output logic             irq_ext,
    output logic             irq_tmr
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [REG_W-1:0] FLAG_MASK =
        (REG_W'(1) << EXT_BIT) | (REG_W'(1) << TMR_BIT);

    sense_mode_e mode_e;
    logic        pin_s;
    logic        edge_evt;
    logic        level_act;
    logic        level_mode;
    logic        ext_flag;
    logic        tmr_flag;
    logic        wr_unused;

    assign mode_e     = sense_mode_e'(sense_mode);
    assign level_mode = (mode_e == SENSE_LOW);
    assign wr_unused  = ^(wr_data & ~FLAG_MASK);

    xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk), .rst_n (rst_n), .d (pin_raw), .q (pin_s)
    );

    xint_sense u_sense (
        .clk (clk), .rst_n (rst_n), .pin_s (pin_s), .mode (mode_e),
        .edge_evt (edge_evt), .level_act (level_act)
    );

    xint_flag_bit u_ext_flag (
        .clk (clk), .rst_n (rst_n), .set_i (edge_evt),
        .wclr_i (wr_en & wr_data[EXT_BIT]), .ack_i (ack_ext),
        .force_clr_i (level_mode), .q (ext_flag)
    );

    xint_flag_bit u_tmr_flag (
        .clk (clk), .rst_n (rst_n), .set_i (tmr_ovf),
        .wclr_i (wr_en & wr_data[TMR_BIT]), .ack_i (ack_tmr),
        .force_clr_i (1'b0), .q (tmr_flag)
    );

    // Assemble the read value; reserved bits and the level-mode flag read zero.
    always_comb begin
        flag_rd          = '0;
        flag_rd[EXT_BIT] = ext_flag & ~level_mode;
        flag_rd[TMR_BIT] = tmr_flag;
    end

    // Gate each request with its enable and the global enable.
    always_comb begin
        irq_ext = gie & ext_en & (level_mode ? level_act : ext_flag);
        irq_tmr = gie & tmr_en & tmr_flag;
    end
endmodule

// File: rtl/xint_sense_flag_chk.sv
// Checker for xint_sense_flag; observes ports only.
module xint_sense_flag_chk #(
    parameter int REG_W   = 8,
    parameter int EXT_BIT = 6,
    parameter int TMR_BIT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sense_mode,
    input logic             ext_en,
    input logic             gie,
    input logic             tmr_ovf,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic             ack_tmr,
    input logic [REG_W-1:0] flag_rd,
    input logic             irq_ext,
    input logic             irq_tmr
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [REG_W-1:0] RSV_MASK =
        ~((REG_W'(1) << EXT_BIT) | (REG_W'(1) << TMR_BIT));

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_rd == '0));

    p_level_no_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_mode == 2'b00) |-> !flag_rd[EXT_BIT]);

    p_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[TMR_BIT] && !tmr_ovf) |=> !flag_rd[TMR_BIT]);

    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_tmr && !tmr_ovf) |=> !flag_rd[TMR_BIT]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_ovf && (ack_tmr || (wr_en && wr_data[TMR_BIT]))) |=> flag_rd[TMR_BIT]);

    p_ovf_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> flag_rd[TMR_BIT]);

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq_ext && !irq_tmr));

    p_ext_irq_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> !irq_ext);

    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd & RSV_MASK) == '0);
endmodule

bind xint_sense_flag xint_sense_flag_chk #(
    .REG_W (REG_W), .EXT_BIT (EXT_BIT), .TMR_BIT (TMR_BIT)
) u_chk (
    .clk (clk), .rst_n (rst_n), .sense_mode (sense_mode), .ext_en (ext_en),
    .gie (gie), .tmr_ovf (tmr_ovf), .wr_en (wr_en), .wr_data (wr_data),
    .ack_tmr (ack_tmr), .flag_rd (flag_rd), .irq_ext (irq_ext), .irq_tmr (irq_tmr)
);

// File: tb/xint_sense_flag_bench.sv
// Directed bench: one task per scenario, inputs driven and outputs sampled on negedge.
module xint_sense_flag_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b1;
    logic [1:0] sense_mode = 2'b00;
    logic       ext_en = 1'b0, tmr_en = 1'b0, gie = 1'b0, tmr_ovf = 1'b0;
    logic       wr_en = 1'b0, ack_ext = 1'b0, ack_tmr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] flag_rd;
    logic       irq_ext, irq_tmr;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    xint_sense_flag u_xint_sense_flag (
        .clk (clk), .rst_n (rst_n), .pin_raw (pin_raw), .sense_mode (sense_mode),
        .ext_en (ext_en), .tmr_en (tmr_en), .gie (gie), .tmr_ovf (tmr_ovf),
        .wr_en (wr_en), .wr_data (wr_data), .ack_ext (ack_ext), .ack_tmr (ack_tmr),
        .flag_rd (flag_rd), .irq_ext (irq_ext), .irq_tmr (irq_tmr)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; step(1); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic t_reset;
        chk("R1 flags", flag_rd, 8'h00);
        chk("R1 irq_ext", {7'd0, irq_ext}, 8'h00);
        chk("R1 irq_tmr", {7'd0, irq_tmr}, 8'h00);
    endtask

    task automatic t_falling;
        sense_mode = 2'b10; gie = 1'b1; ext_en = 1'b1; step(3);
        pin_raw = 1'b0; step(2);
        chk("R12 no flag before third edge", flag_rd, 8'h00);
        step(1);
        chk("R2 falling sets", flag_rd, 8'h40);
        chk("R10 irq follows flag", {7'd0, irq_ext}, 8'h01);
        wr(8'h00);
        chk("R6 write 0 keeps", flag_rd, 8'h40);
        wr(8'h40);
        chk("R6 write 1 clears", flag_rd, 8'h00);
        pin_raw = 1'b1; step(5);
        chk("R2 rising ignored", flag_rd, 8'h00);
    endtask

    task automatic t_rising;
        sense_mode = 2'b11;
        pin_raw = 1'b0; step(5);
        chk("R3 falling ignored", flag_rd, 8'h00);
        pin_raw = 1'b1; step(3);
        chk("R3 rising sets", flag_rd, 8'h40);
        ack_ext = 1'b1; step(1); ack_ext = 1'b0;
        chk("R7 ack clears ext", flag_rd, 8'h00);
    endtask

    task automatic t_change;
        sense_mode = 2'b01;
        pin_raw = 1'b0; step(3);
        chk("R4 fall sets", flag_rd, 8'h40);
        wr(8'h40);
        pin_raw = 1'b1; step(3);
        chk("R4 rise sets", flag_rd, 8'h40);
        wr(8'h40);
    endtask

    task automatic t_enables;
        sense_mode = 2'b10; gie = 1'b0; step(2);
        pin_raw = 1'b0; step(3);
        chk("R10 flag sets with gie low", flag_rd, 8'h40);
        chk("R10 no irq with gie low", {7'd0, irq_ext}, 8'h00);
        gie = 1'b1; ext_en = 1'b0; step(1);
        chk("R10 no irq with ext_en low", {7'd0, irq_ext}, 8'h00);
        ext_en = 1'b1; step(1);
        chk("R10 irq with all set", {7'd0, irq_ext}, 8'h01);
    endtask

    task automatic t_level;
        // flag is set from t_enables, pin low
        sense_mode = 2'b00; step(1);
        chk("R5 flag reads zero in level", flag_rd, 8'h00);
        chk("R5 irq while low", {7'd0, irq_ext}, 8'h01);
        pin_raw = 1'b1; step(1);
        chk("R12 level still held one edge", {7'd0, irq_ext}, 8'h01);
        step(1);
        chk("R5 irq drops when high", {7'd0, irq_ext}, 8'h00);
        pin_raw = 1'b0; step(2);
        chk("R5 irq returns when low", {7'd0, irq_ext}, 8'h01);
        gie = 1'b0; step(1);
        chk("R5 level gated by gie", {7'd0, irq_ext}, 8'h00);
        gie = 1'b1; sense_mode = 2'b10; step(1);
        chk("R5 stored flag discarded", flag_rd, 8'h00);
        pin_raw = 1'b1; step(4);
    endtask

    task automatic t_timer;
        tmr_en = 1'b0;
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
        chk("R9 overflow sets", flag_rd, 8'h10);
        chk("R9 no irq with tmr_en low", {7'd0, irq_tmr}, 8'h00);
        tmr_en = 1'b1; step(1);
        chk("R9 irq with all set", {7'd0, irq_tmr}, 8'h01);
        ack_tmr = 1'b1; step(1); ack_tmr = 1'b0;
        chk("R7 ack clears timer", flag_rd, 8'h00);
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
        wr(8'h10);
        chk("R6 write 1 clears timer", flag_rd, 8'h00);
    endtask

    task automatic t_collision;
        tmr_ovf = 1'b1; wr_en = 1'b1; wr_data = 8'h10; step(1);
        tmr_ovf = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
        chk("R8 overflow beats write clear", flag_rd, 8'h10);
        tmr_ovf = 1'b1; ack_tmr = 1'b1; step(1);
        tmr_ovf = 1'b0; ack_tmr = 1'b0;
        chk("R8 overflow beats ack", flag_rd, 8'h10);
        wr(8'h10);
        pin_raw = 1'b0; step(2);
        wr(8'h40);
        chk("R8 edge beats write clear", flag_rd, 8'h40);
        wr(8'h40);
    endtask

    task automatic t_reserved;
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
        pin_raw = 1'b1; step(3);
        sense_mode = 2'b01; pin_raw = 1'b0; step(3);
        wr(8'hAF);
        chk("R11 reserved write ignored", flag_rd, 8'h50);
        wr(8'h50);
        chk("R11 reserved read zero", flag_rd, 8'h00);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_falling();
        t_rising();
        t_change();
        t_enables();
        t_level();
        t_timer();
        t_collision();
        t_reserved();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule